// File: doc/BRIEF.md
# Transmit DMA Request Generator

This block decides when a transmit DMA engine should ask the shared bus arbiter for a burst. The arbiter also serves the receive DMA. A burst moves frame data from host memory into a transmit FIFO of up to 2048 bytes. The block reads two values from the FIFO every cycle: its free byte count and its occupied byte count.

Two programmable 11-bit byte thresholds control the decision. The burst threshold holds back an ordinary request until a long burst fits into the free space. The urgent threshold raises a priority request once the FIFO is close to running dry, whatever the free space is. No request of either kind starts unless the DMA engine reports frame data still pending.

A request, once raised, stays up until the arbiter grants it. It then stays up through the burst and falls on the cycle after burst completion, and the block re-evaluates from there. Both thresholds are loaded through a single write port with a select bit.

Top module: `tx_dma_req_gen`

## Requirements
- R1: After reset both request outputs are low, the burst threshold is 512 and the urgent threshold is 0, so no urgent request can arise before the urgent threshold is written.
- R2: While idle, no request of either kind is raised when `data_pend` is low, whatever the FIFO counts are.
- R3: While idle with `data_pend` high, `req_norm` rises one clock after the cycle in which `fifo_free` is greater than or equal to the burst threshold, provided the urgent condition is absent.
- R4: While idle, a free count below the burst threshold raises no normal request.
- R5: While idle with `data_pend` high, `req_urg` rises one clock after the cycle in which `fifo_used` is strictly below the urgent threshold, whatever the free count is.
- R6: When the burst and urgent conditions hold together, only `req_urg` is raised. The two outputs are never high at the same time.
- R7: A raised request stays asserted until `grant` is sampled high, even if `data_pend` or the FIFO counts change meanwhile.
- R8: After a grant the request stays asserted until `burst_done` is sampled high. It is low in the following cycle, and a new request can rise no earlier than one cycle later.
- R9: While a normal request waits for a grant, an urgent condition converts it to an urgent request on the next clock, and it stays urgent until the burst completes.
- R10: A write with `cfg_we` high loads `cfg_wdata` into the burst threshold when `cfg_sel` is 0, or into the urgent threshold when `cfg_sel` is 1. The other threshold is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | 0 selects burst threshold, 1 selects urgent threshold |
| cfg_wdata | input | 11 | Threshold value in bytes |
| fifo_free | input | 12 | Free bytes in the transmit FIFO |
| fifo_used | input | 12 | Occupied bytes in the transmit FIFO |
| data_pend | input | 1 | Frame data is waiting to be moved |
| grant | input | 1 | Arbiter grants the pending request |
| burst_done | input | 1 | Granted burst has finished |
| req_norm | output | 1 | Normal burst request |
| req_urg | output | 1 | Urgent request |

## Verification
A corrupted threshold register shows up as a wrong request type, or a missing request, one clock after a FIFO count crosses the value it should hold. The bench therefore probes each comparison exactly at and one byte past its boundary. A sequencing fault has its own signs at the ports. A request may drop before the grant, stay up after `burst_done`, or fail to upgrade from normal to urgent. Each of these appears within one cycle of the triggering handshake, and the bench samples that very cycle.

// File: rtl/tx_dma_req_gen.sv
module tx_dma_req_gen #(
  parameter int FIFO_BYTES = 2048,
  parameter int BURST_RST  = 512,
  parameter int URG_RST    = 0,
  localparam int CW = $clog2(FIFO_BYTES) + 1,
  localparam int TW = CW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [TW-1:0] cfg_wdata,
  input  logic [CW-1:0] fifo_free,
  input  logic [CW-1:0] fifo_used,
  input  logic          data_pend,
  input  logic          grant,
  input  logic          burst_done,
  output logic          req_norm,
  output logic          req_urg
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER} st_t;

  st_t           st;
  logic [TW-1:0] burst_th, urg_th;
  logic          rn_q, ru_q;

  wire urg_hit  = {1'b0, urg_th} > fifo_used;
  wire brst_hit = fifo_free >= {1'b0, burst_th};

  assign req_norm = rn_q;
  assign req_urg  = ru_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_th <= TW'(BURST_RST);
      urg_th   <= TW'(URG_RST);
    end else if (cfg_we) begin
      if (cfg_sel) urg_th   <= cfg_wdata;
      else         burst_th <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      rn_q <= 1'b0;
      ru_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (data_pend && (urg_hit || brst_hit)) begin
            st   <= S_WAIT;
            ru_q <= urg_hit;
            rn_q <= !urg_hit;
          end
        S_WAIT: begin
          if (urg_hit) begin
            ru_q <= 1'b1;
            rn_q <= 1'b0;
          end
          if (grant) st <= S_XFER;
        end
        S_XFER:
          if (burst_done) begin
            st   <= S_IDLE;
            rn_q <= 1'b0;
            ru_q <= 1'b0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_norm && req_urg));

  assert_no_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !data_pend) |=> !(req_norm || req_urg));

  assert_urgent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && data_pend && urg_hit) |=> req_urg);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !grant) |=> (req_norm || req_urg));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && burst_done) |=> !(req_norm || req_urg));

  assert_sticky_urg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_urg && st != S_IDLE && !(st == S_XFER && burst_done)) |=> req_urg);

endmodule

// File: tb/tx_dma_req_gen_test.sv
module tx_dma_req_gen_test;

  logic        clk = 1'b0;
  logic        rst_n, cfg_we, cfg_sel, data_pend, grant, burst_done;
  logic [10:0] cfg_wdata;
  logic [11:0] fifo_free, fifo_used;
  logic        req_norm, req_urg;
  int          checks = 0;
  int          fails  = 0;
  bit          done_flag = 1'b0;

  always #2 clk = ~clk;

  tx_dma_req_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fifo_free(fifo_free), .fifo_used(fifo_used),
    .data_pend(data_pend), .grant(grant), .burst_done(burst_done),
    .req_norm(req_norm), .req_urg(req_urg)
  );

  typedef struct packed {
    logic [10:0] bth;
    logic [10:0] uth;
    logic [11:0] free;
    logic [11:0] used;
    logic        pend;
    logic        en;
    logic        eu;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{11'd512,  11'd0,    12'd600,  12'd100,  1'b1, 1'b1, 1'b0},
    '{11'd512,  11'd0,    12'd511,  12'd100,  1'b1, 1'b0, 1'b0},
    '{11'd512,  11'd0,    12'd512,  12'd100,  1'b1, 1'b1, 1'b0},
    '{11'd512,  11'd64,   12'd100,  12'd63,   1'b1, 1'b0, 1'b1},
    '{11'd512,  11'd64,   12'd100,  12'd64,   1'b1, 1'b0, 1'b0},
    '{11'd512,  11'd64,   12'd1000, 12'd10,   1'b1, 1'b0, 1'b1},
    '{11'd512,  11'd64,   12'd2048, 12'd0,    1'b0, 1'b0, 1'b0},
    '{11'd2047, 11'd0,    12'd2048, 12'd0,    1'b1, 1'b1, 1'b0},
    '{11'd0,    11'd2047, 12'd0,    12'd2046, 1'b1, 1'b0, 1'b1}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic en, input logic eu, input string tag);
    checks++;
    if (req_norm !== en || req_urg !== eu) begin
      fails++;
      $display("FAIL %s: got norm=%b urg=%b, expected norm=%b urg=%b",
               tag, req_norm, req_urg, en, eu);
    end
  endtask

  task automatic wr(input logic sel, input logic [10:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic finish_burst();
    grant = 1'b1;
    step();
    grant = 1'b0; burst_done = 1'b1; data_pend = 1'b0;
    step();
    burst_done = 1'b0;
    step();
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    fifo_free = '0; fifo_used = '0; data_pend = 1'b0;
    grant = 1'b0; burst_done = 1'b0;
    repeat (3) step();
    chk(1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    step();
    chk(1'b0, 1'b0, "R1 after reset");

    fifo_free = 12'd512; fifo_used = 12'd100; data_pend = 1'b1;
    step();
    chk(1'b1, 1'b0, "R1 burst threshold resets to 512");
    finish_burst();
    fifo_free = 12'd511; data_pend = 1'b1;
    step();
    chk(1'b0, 1'b0, "R1 511 below reset burst threshold");
    data_pend = 1'b0; step();
    fifo_free = 12'd0; fifo_used = 12'd0; data_pend = 1'b1;
    step();
    chk(1'b0, 1'b0, "R1 urgent threshold resets to 0");
    data_pend = 1'b0; step();

    for (int i = 0; i < 9; i++) begin
      wr(1'b0, VECS[i].bth);
      wr(1'b1, VECS[i].uth);
      fifo_free = VECS[i].free; fifo_used = VECS[i].used;
      data_pend = VECS[i].pend;
      step();
      chk(VECS[i].en, VECS[i].eu,
          $sformatf("R2/R3/R4/R5/R6/R10 vector %0d", i));
      if (VECS[i].en || VECS[i].eu) finish_burst();
      else begin data_pend = 1'b0; step(); end
    end

    wr(1'b0, 11'd512);
    wr(1'b1, 11'd64);
    fifo_free = 12'd1000; fifo_used = 12'd500; data_pend = 1'b1;
    step();
    chk(1'b1, 1'b0, "R3 normal request");
    data_pend = 1'b0; fifo_free = 12'd0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(1'b1, 1'b0, "R7 held without grant");
    end
    fifo_used = 12'd10;
    step();
    chk(1'b0, 1'b1, "R9 upgrade to urgent");
    fifo_used = 12'd500;
    step();
    chk(1'b0, 1'b1, "R9 stays urgent");
    grant = 1'b1;
    step();
    grant = 1'b0;
    chk(1'b0, 1'b1, "R8 held after grant");
    step();
    chk(1'b0, 1'b1, "R8 held during burst");
    data_pend = 1'b1; fifo_free = 12'd1000; burst_done = 1'b1;
    step();
    burst_done = 1'b0;
    chk(1'b0, 1'b0, "R8 low after burst_done");
    step();
    chk(1'b1, 1'b0, "R8 re-request after gap");
    finish_burst();

    wr(1'b0, 11'd100);
    fifo_free = 12'd100; fifo_used = 12'd63; data_pend = 1'b1;
    step();
    chk(1'b0, 1'b1, "R10 urgent threshold kept by burst write");
    finish_burst();
    fifo_used = 12'd64; data_pend = 1'b1;
    step();
    chk(1'b1, 1'b0, "R10 burst threshold now 100");
    finish_burst();

    done_flag = 1'b1;
    report();
  end

endmodule